// File: doc/BRIEF.md
# Serial Flash Row Programming Sequencer

This block lives on the host side of an in-system programming link. It programs one 64-byte row of a target microcontroller's code flash over a two-wire serial link: a clock line driven by the host and a data line the host drives while it sends. Each transfer on the wire is a frame made of a 4-bit command code followed by a 16-bit payload.

A single-cycle start pulse supplies a row-aligned byte address and a dwell count. The sequencer then emits a fixed script of 40 frames. It first sets the target's write-enable bit, then loads the target's three-byte table pointer, then streams 32 words from a local register file. Every word except the last uses the write-and-increment command, and the last uses the write-and-program command. A final no-operation frame follows, in which the fourth clock pulse is held high for the programming dwell.

Word slots whose valid bit is clear are sent as FFFF, so the target never reprograms stale buffer contents. A start address that is not on a row boundary is refused with an error pulse.

Top module: `rowprog_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, prog_clk, prog_data_oe, busy, done and align_err are all 0.
- R2: Each frame is 20 bits, sent least significant bit first: the 4-bit code first, then the 16-bit payload. Each bit is placed on prog_data at the rising edge of prog_clk and held until the falling edge. prog_data_oe is 1 whenever prog_clk is high.
- R3: Within a frame, every prog_clk high phase lasts HI_CYC system cycles and every low phase lasts LO_CYC system cycles. The only exception is the dwell pulse of R7.
- R4: The script opens with seven frames that all use code 0000. Their payloads are 84A6, then 0E followed by address bits [23:16] zero-extended, then 6EF8, then 0E with bits [15:8], then 6EF7, then 0E with bits [7:0], then 6EF6.
- R5: Frames 8 to 38 carry buffer words 0 to 30 in ascending order with code 1101. buf_idx selects the word being fetched.
- R6: Frame 39 carries buffer word 31 with code 1111. Frame 40 is a code 0000 frame with payload 0000, and no further frames follow.
- R7: In frame 40, the fourth clock pulse stays high for the number of system cycles given by dwell_cycles when start was accepted.
- R8: A word whose buf_valid is 0 is sent as FFFF in place of buf_data.
- R9: A start whose address has a nonzero value in bits [5:0] gives a one-cycle align_err pulse in the next cycle. busy stays 0 and no frame is sent.
- R10: busy rises in the cycle after an accepted start. After the last low phase of frame 40, done pulses for one cycle, and busy is 0 in that same cycle.
- R11: A start pulse while busy is 1 is ignored: the frame stream continues unchanged and align_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to program a row |
| start_addr | input | 22 | Byte address of the row, must be 64-byte aligned |
| dwell_cycles | input | 24 | Programming dwell in system cycles, sampled at start |
| buf_idx | output | 5 | Word index read from the local buffer |
| buf_data | input | 16 | Word read from the buffer at buf_idx |
| buf_valid | input | 1 | Valid bit of that word; 0 requests FFFF padding |
| prog_clk | output | 1 | Serial programming clock |
| prog_data | output | 1 | Serial programming data |
| prog_data_oe | output | 1 | Output enable for the bidirectional data pad |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |
| align_err | output | 1 | One-cycle pulse when a misaligned start is refused |

## Verification
busy and align_err answer one system cycle after the start pulse is sampled, and the bench reads them at the falling system-clock edge of that cycle. prog_clk first rises two cycles after an accepted start. Because frame-to-frame spacing is not part of the contract, the frames are decoded straight off the wire: data is taken at each falling prog_clk, and high and low phase lengths are measured by counting samples. Each decoded frame is then compared with the next item queued by the driver, so no check depends on an absolute cycle count. done is awaited and then checked together with busy in the same sample, and the expected queue must be empty one cycle later.

// File: rtl/rowprog_pkg.sv
// Package: shared frame type, command codes and target opcodes for the
// row programming sequencer. Assumes a 4-bit code plus 16-bit payload frame.
package rowprog_pkg;
    localparam int CODE_W     = 4;
    localparam int PAYLOAD_W  = 16;
    localparam int FRAME_BITS = CODE_W + PAYLOAD_W;
    localparam int HDR_FRAMES = 7;

    localparam logic [3:0]  CODE_CORE   = 4'b0000;
    localparam logic [3:0]  CODE_WR_INC = 4'b1101;
    localparam logic [3:0]  CODE_WR_GO  = 4'b1111;

    localparam logic [15:0] OP_SET_WREN = 16'h84A6;
    localparam logic [7:0]  OP_LIT      = 8'h0E;
    localparam logic [7:0]  OP_STORE    = 8'h6E;
    localparam logic [7:0]  PTR_REG_TOP = 8'hF8;
    localparam logic [15:0] PAD_WORD    = 16'hFFFF;

    typedef struct packed {
        logic [CODE_W-1:0]    code;
        logic [PAYLOAD_W-1:0] payload;
        logic                 stretch;
    } frame_t;
endpackage

// File: rtl/rowprog_frame_gen.sv
// Frame generator: computes the command code and payload of script frame
// frame_idx from the latched row address and the buffer word it selects.
// Assumes ADDR_W <= 24 and that the buffer read is combinational.
module rowprog_frame_gen
    import rowprog_pkg::*;
#(
    parameter int WORDS  = 32,
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]         frame_idx,
    input  logic [ADDR_W-1:0]        row_addr,
    input  logic [15:0]              word_data,
    input  logic                     word_valid,
    output logic [$clog2(WORDS)-1:0] word_idx,
    output frame_t                   frm
);
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int LAST_WORD = HDR_FRAMES + WORDS - 1;

    logic [23:0] addr24;
    logic [15:0] ptr_load  [3];
    logic [15:0] ptr_store [3];
    logic [1:0]  ptr_step;

    assign addr24 = 24'(row_addr);

    // One load/store opcode pair per pointer byte, upper byte first
    for (genvar g = 0; g < 3; g++) begin : g_ptr
        assign ptr_load[g]  = {OP_LIT, addr24[8*(2-g) +: 8]};
        assign ptr_store[g] = {OP_STORE, PTR_REG_TOP - 8'(g)};
    end

    assign ptr_step = 2'((frame_idx - IDX_W'(1)) >> 1);
    assign word_idx = WIDX_W'(frame_idx - IDX_W'(HDR_FRAMES));

    // Select the frame contents for the current script position
    always_comb begin
        frm = '{code: CODE_CORE, payload: 16'h0000, stretch: 1'b0};
        if (frame_idx == '0) begin
            frm.payload = OP_SET_WREN;
        end else if (frame_idx < IDX_W'(HDR_FRAMES)) begin
            frm.payload = frame_idx[0] ? ptr_load[ptr_step] : ptr_store[ptr_step];
        end else if (frame_idx <= IDX_W'(LAST_WORD)) begin
            frm.code    = (frame_idx == IDX_W'(LAST_WORD)) ? CODE_WR_GO : CODE_WR_INC;
            frm.payload = word_valid ? word_data : PAD_WORD;
        end else begin
            frm.stretch = 1'b1;
        end
    end
endmodule

// File: rtl/rowprog_shifter.sv
// Frame shifter: serializes one 20-bit frame LSB first on a generated clock.
// Data changes with the rising edge, the target samples on the falling edge.
// In a stretch frame the high phase of bit STRETCH_BIT lasts 'dwell' cycles
// (zero acts as one). Assumes HI_CYC, LO_CYC >= 1 and fit in DWELL_W bits.
module rowprog_shifter
    import rowprog_pkg::*;
#(
    parameter int HI_CYC      = 2,
    parameter int LO_CYC      = 2,
    parameter int DWELL_W     = 24,
    parameter int STRETCH_BIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  frame_t             frm,
    input  logic [DWELL_W-1:0] dwell,
    output logic               pgc,
    output logic               pgd,
    output logic               pgd_oe,
    output logic               frame_done
);
    localparam int BIT_W = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} sh_state_t;

    sh_state_t               state;
    logic [FRAME_BITS-1:0]   shreg;
    logic [BIT_W-1:0]        bit_idx;
    logic [DWELL_W-1:0]      cnt;
    logic                    stretch_q;

    function automatic logic [DWELL_W-1:0] hi_len(input logic [BIT_W-1:0] b,
                                                  input logic s,
                                                  input logic [DWELL_W-1:0] d);
        if (s && b == BIT_W'(STRETCH_BIT))
            return (d == '0) ? DWELL_W'(1) : d;
        return DWELL_W'(HI_CYC);
    endfunction

    // Bit timing state machine and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            cnt        <= '0;
            stretch_q  <= 1'b0;
            pgc        <= 1'b0;
            pgd        <= 1'b0;
            pgd_oe     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                S_IDLE: if (launch) begin
                    shreg     <= {frm.payload, frm.code};
                    stretch_q <= frm.stretch;
                    bit_idx   <= '0;
                    pgc       <= 1'b1;
                    pgd       <= frm.code[0];
                    pgd_oe    <= 1'b1;
                    cnt       <= hi_len('0, frm.stretch, dwell) - DWELL_W'(1);
                    state     <= S_HI;
                end
                S_HI: begin
                    if (cnt == '0) begin
                        pgc   <= 1'b0;
                        cnt   <= DWELL_W'(LO_CYC - 1);
                        state <= S_LO;
                    end else begin
                        cnt <= cnt - DWELL_W'(1);
                    end
                end
                S_LO: begin
                    if (cnt != '0) begin
                        cnt <= cnt - DWELL_W'(1);
                    end else if (bit_idx == BIT_W'(FRAME_BITS - 1)) begin
                        pgd_oe     <= 1'b0;
                        pgd        <= 1'b0;
                        frame_done <= 1'b1;
                        state      <= S_IDLE;
                    end else begin
                        bit_idx <= bit_idx + BIT_W'(1);
                        shreg   <= shreg >> 1;
                        pgd     <= shreg[1];
                        pgc     <= 1'b1;
                        cnt     <= hi_len(bit_idx + BIT_W'(1), stretch_q, dwell) - DWELL_W'(1);
                        state   <= S_HI;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rowprog_seq_ctl.sv
// Sequence controller: accepts a start, checks row alignment, latches the
// address and dwell, and steps the frame index one frame at a time.
// Starts are ignored while busy. Assumes one frame_done per launch.
module rowprog_seq_ctl
    import rowprog_pkg::*;
#(
    parameter int WORDS     = 32,
    parameter int ROW_BYTES = 64,
    parameter int ADDR_W    = 22,
    parameter int DWELL_W   = 24,
    parameter int IDX_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [DWELL_W-1:0] dwell_in,
    input  logic               frame_done,
    output logic               launch,
    output logic [IDX_W-1:0]   frame_idx,
    output logic [ADDR_W-1:0]  row_addr,
    output logic [DWELL_W-1:0] dwell_q,
    output logic               busy,
    output logic               done,
    output logic               align_err
);
    localparam int OFS_W      = $clog2(ROW_BYTES);
    localparam int LAST_FRAME = HDR_FRAMES + WORDS;

    // Start acceptance, frame stepping and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch    <= 1'b0;
            frame_idx <= '0;
            row_addr  <= '0;
            dwell_q   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            align_err <= 1'b0;
        end else begin
            launch    <= 1'b0;
            done      <= 1'b0;
            align_err <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (start_addr[OFS_W-1:0] != '0) begin
                        align_err <= 1'b1;
                    end else begin
                        busy      <= 1'b1;
                        row_addr  <= start_addr;
                        dwell_q   <= dwell_in;
                        frame_idx <= '0;
                        launch    <= 1'b1;
                    end
                end
            end else if (frame_done) begin
                if (frame_idx == IDX_W'(LAST_FRAME)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    frame_idx <= frame_idx + IDX_W'(1);
                    launch    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rowprog_seq.sv
// Top: row programming sequencer. Joins the controller, the frame generator
// and the serial shifter. Assumes buf_data/buf_valid follow buf_idx in the
// same cycle (local register file read).
module rowprog_seq
    import rowprog_pkg::*;
#(
    parameter int WORDS     = 32,
    parameter int ROW_BYTES = 64,
    parameter int ADDR_W    = 22,
    parameter int DWELL_W   = 24,
    parameter int HI_CYC    = 2,
    parameter int LO_CYC    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        start_addr,
    input  logic [DWELL_W-1:0]       dwell_cycles,
    output logic [$clog2(WORDS)-1:0] buf_idx,
    input  logic [15:0]              buf_data,
    input  logic                     buf_valid,
    output logic                     prog_clk,
    output logic                     prog_data,
    output logic                     prog_data_oe,
    output logic                     busy,
    output logic                     done,
    output logic                     align_err
);
    localparam int N_FRAMES = HDR_FRAMES + WORDS + 1;
    localparam int IDX_W    = $clog2(N_FRAMES + 1);

    logic               launch;
    logic               frame_done;
    logic [IDX_W-1:0]   frame_idx;
    logic [ADDR_W-1:0]  row_addr;
    logic [DWELL_W-1:0] dwell_q;
    frame_t             frm;

    rowprog_seq_ctl #(
        .WORDS(WORDS), .ROW_BYTES(ROW_BYTES), .ADDR_W(ADDR_W),
        .DWELL_W(DWELL_W), .IDX_W(IDX_W)
    ) ctl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .dwell_in(dwell_cycles), .frame_done(frame_done), .launch(launch),
        .frame_idx(frame_idx), .row_addr(row_addr), .dwell_q(dwell_q),
        .busy(busy), .done(done), .align_err(align_err)
    );

    rowprog_frame_gen #(
        .WORDS(WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) gen_i (
        .frame_idx(frame_idx), .row_addr(row_addr), .word_data(buf_data),
        .word_valid(buf_valid), .word_idx(buf_idx), .frm(frm)
    );

    rowprog_shifter #(
        .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .DWELL_W(DWELL_W), .STRETCH_BIT(3)
    ) sh_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .frm(frm), .dwell(dwell_q),
        .pgc(prog_clk), .pgd(prog_data), .pgd_oe(prog_data_oe),
        .frame_done(frame_done)
    );
endmodule

// File: rtl/rowprog_seq_chk.sv
// Checker: port-level protocol properties of the row programming sequencer,
// bound to every instance of the top module.
module rowprog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic prog_clk,
    input logic prog_data,
    input logic prog_data_oe,
    input logic busy,
    input logic done,
    input logic align_err
);
    p_data_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_clk && $past(prog_clk)) |-> $stable(prog_data))
        else $error("data moved while clock high");

    p_oe_with_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_clk |-> prog_data_oe)
        else $error("clock high without drive");

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done while busy");

    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start))
        else $error("busy without start");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !prog_clk)
        else $error("clock toggles while idle");

    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> !align_err)
        else $error("align_err longer than one cycle");

    p_err_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !busy)
        else $error("align_err while busy");
endmodule

bind rowprog_seq rowprog_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_clk(prog_clk),
    .prog_data(prog_data), .prog_data_oe(prog_data_oe), .busy(busy),
    .done(done), .align_err(align_err)
);

// File: tb/rowprog_seq_tb_top.sv
// Scoreboard bench: the driver queues expected frames, the monitor decodes
// frames off the serial wires and compares them in order.
module rowprog_seq_tb_top;
    localparam int HI = 2;
    localparam int LO = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [21:0] start_addr = '0;
    logic [23:0] dwell_cycles = '0;
    logic [4:0]  buf_idx;
    logic [15:0] buf_data;
    logic        buf_valid;
    logic        prog_clk, prog_data, prog_data_oe, busy, done, align_err;

    logic [15:0] mem   [32];
    logic        vmask [32];

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [3:0]  code;
        logic [15:0] payload;
        int          kind;   // 0 setup, 1 word, 2 last/nop, 3 padded word
        bit          nop;
    } exp_t;
    exp_t q[$];
    int   exp_dwell;

    always #10 clk = ~clk;

    assign buf_data  = mem[buf_idx];
    assign buf_valid = vmask[buf_idx];

    rowprog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .dwell_cycles(dwell_cycles), .buf_idx(buf_idx), .buf_data(buf_data),
        .buf_valid(buf_valid), .prog_clk(prog_clk), .prog_data(prog_data),
        .prog_data_oe(prog_data_oe), .busy(busy), .done(done),
        .align_err(align_err)
    );

    function automatic string tag_of(int kind);
        case (kind)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [3:0] c, logic [15:0] p, int k, bit n);
        exp_t e;
        e.code = c; e.payload = p; e.kind = k; e.nop = n;
        q.push_back(e);
    endtask

    // Driver: queue the full expected script for one row
    task automatic expect_row(logic [21:0] a, int dw);
        logic [23:0] a24 = 24'(a);
        exp_dwell = dw;
        push(4'b0000, 16'h84A6, 0, 0);
        push(4'b0000, {8'h0E, a24[23:16]}, 0, 0);
        push(4'b0000, 16'h6EF8, 0, 0);
        push(4'b0000, {8'h0E, a24[15:8]}, 0, 0);
        push(4'b0000, 16'h6EF7, 0, 0);
        push(4'b0000, {8'h0E, a24[7:0]}, 0, 0);
        push(4'b0000, 16'h6EF6, 0, 0);
        for (int k = 0; k < 31; k++)
            push(4'b1101, vmask[k] ? mem[k] : 16'hFFFF, vmask[k] ? 1 : 3, 0);
        push(4'b1111, vmask[31] ? mem[31] : 16'hFFFF, vmask[31] ? 2 : 3, 0);
        push(4'b0000, 16'h0000, 2, 1);
    endtask

    task automatic pulse_start(logic [21:0] a, logic [23:0] dw);
        start_addr   = a;
        dwell_cycles = dw;
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        check(!busy, "R10", "busy in done cycle", busy, 0);
        @(negedge clk);
        check(!done, "R10", "done width", done, 0);
        check(q.size() == 0, "R6", "frames left in queue", q.size(), 0);
    endtask

    // Monitor: decode frames at falling prog_clk and measure phases
    logic        prev_clk = 1'b0;
    logic        last_d = 1'b0;
    logic [19:0] bits = '0;
    int          bitpos = 0;
    int          hi_cnt = 0;
    int          lo_cnt = 0;
    int          dwell_meas = 0;
    bit          timing_bad = 0;
    exp_t        cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_clk) begin
                if (!prev_clk) begin
                    if (bitpos != 0 && lo_cnt != LO) timing_bad = 1;
                    hi_cnt = 1;
                end else begin
                    hi_cnt++;
                end
                last_d = prog_data;
                if (!prog_data_oe) timing_bad = 1;
            end else if (prev_clk) begin
                if (bitpos == 3 && q.size() != 0 && q[0].nop) dwell_meas = hi_cnt;
                else if (hi_cnt != HI) timing_bad = 1;
                bits[bitpos] = last_d;
                bitpos++;
                lo_cnt = 1;
                if (bitpos == 20) begin
                    if (q.size() == 0) begin
                        check(0, "R11", "unexpected frame", int'(bits), 0);
                    end else begin
                        cur = q.pop_front();
                        check(bits == {cur.payload, cur.code}, tag_of(cur.kind),
                              "frame bits", int'(bits), int'({cur.payload, cur.code}));
                        check(!timing_bad, "R3", "phase lengths", 1, 0);
                        if (cur.nop)
                            check(dwell_meas == exp_dwell, "R7", "dwell length",
                                  dwell_meas, exp_dwell);
                    end
                    bitpos = 0;
                    timing_bad = 0;
                end
            end else begin
                lo_cnt++;
            end
            prev_clk = prog_clk;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(150000 * 20);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            mem[k]   = 16'h1000 + 16'(k * 16'h0111);
            vmask[k] = 1'b1;
        end
        repeat (4) @(negedge clk);
        check(!prog_clk && !prog_data_oe, "R1", "pins in reset",
              {prog_clk, prog_data_oe}, 0);
        check(!busy && !done && !align_err, "R1", "status in reset",
              {busy, done, align_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !prog_clk, "R1", "first cycle after reset",
              {busy, prog_clk}, 0);

        // Row 1: all words valid, R2 R4 R5 R6 R7
        expect_row(22'h012340, 50);
        pulse_start(22'h012340, 24'd50);
        check(busy, "R10", "busy after start", busy, 1);
        wait_done();

        // Row 2: top row, padded words and short dwell, R8
        vmask[0] = 1'b0; vmask[13] = 1'b0; vmask[31] = 1'b0;
        for (int k = 0; k < 32; k++) mem[k] = ~mem[k];
        expect_row(22'h3FFFC0, 7);
        pulse_start(22'h3FFFC0, 24'd7);
        wait_done();

        // Misaligned start refused, R9
        pulse_start(22'h000021, 24'd5);
        check(align_err && !busy, "R9", "error pulse", {align_err, busy}, 2);
        @(negedge clk);
        check(!align_err, "R9", "error width", align_err, 0);
        repeat (40) @(negedge clk);
        check(!prog_clk && !busy, "R9", "no frame after error", {prog_clk, busy}, 0);

        // Start while busy ignored, R11
        for (int k = 0; k < 32; k++) vmask[k] = 1'b1;
        expect_row(22'h000080, 12);
        pulse_start(22'h000080, 24'd12);
        repeat (500) @(negedge clk);
        pulse_start(22'h000101, 24'd3);
        check(!align_err && busy, "R11", "start while busy", {align_err, busy}, 1);
        pulse_start(22'h000200, 24'd3);
        check(busy, "R11", "still busy", busy, 1);
        wait_done();
        repeat (200) @(negedge clk);
        check(!busy && q.size() == 0, "R11", "no extra run", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule